// File: doc/BRIEF.md
# Wide-Screen Signaling Line Inserter

This block sits in the luma path of a digital video encoder. On one or two chosen lines of each frame it takes over the luma sample stream and sends a short two-level burst that carries a wide-screen signaling word. The encoder supplies a frame-start strobe, a line-start strobe with the absolute line number, and a running horizontal position. Software supplies two enable bits, a 20-bit data word, a 20-bit rate increment, the high level code, the start offset and a 525/625-line select. All of these settings are captured together at frame start.

The burst is made of bit cells. Its pace comes from a 20-bit phase accumulator that adds the programmed increment on every clock. A carry out of the top bit closes a cell, and the top bit of the accumulator tells the first half-cell from the second. Every cell is biphase coded. The burst opens with two run-in cells, then two start-code cells, then the data bits with the lowest bit first. The inserter does not compute a checksum. In 525-line mode the six upper bits of the word are sent exactly as written.

The sequencer is a state machine with five states. **IDLE**: nothing is sent, and it waits for a selected line. **ARMED**: a selected line has begun, and it waits for the start offset. **RUNIN**: it sends the run-in cells. **START**: it sends the start code. **DATA**: it sends the payload. The transitions are:
- *line_hit*: IDLE or ARMED goes to ARMED on a line start whose line is selected.
- *line_miss*: ARMED goes to IDLE on a line start whose line is not selected.
- *at_offset*: ARMED goes to RUNIN when the horizontal position equals the offset.
- *runin_done*: RUNIN goes to START on the carry of the last run-in cell.
- *start_done*: START goes to DATA on the carry of the last start cell.
- *data_done*: DATA goes to IDLE on the carry of the last valid bit.
- *line_abort*: any sending state goes to ARMED or IDLE on a new line start.

Top module: `wss_line_inserter`

## Requirements
- R1: With 525-line mode selected (std625=0), the odd-field enable alone gates insertion on line 20, and the even-field enable alone gates insertion on line 283. No other line, including line 23, is used.
- R2: With 625-line mode selected (std625=1), insertion takes place only on line 23 and only when the odd-field enable is set. The even-field enable has no effect, and lines 20 and 283 carry nothing.
- R3: In 525-line mode the payload is all 20 bits of wss_word, sent from bit 0 up to bit 19. Bits 19 to 14 (the checksum field) go out exactly as written.
- R4: In 625-line mode only wss_word bits 13 to 0 are sent, from bit 0 upward. Bits 19 to 14 have no effect on the output.
- R5: ins_active first reads high in the clock cycle that follows the rising edge at which hpos equals the latched start offset.
- R6: Whenever ins_active is low, luma_out equals the black code (64 by default).
- R7: During a burst, a 20-bit accumulator starts at zero and adds the latched rate_inc on every clock. The carry out of bit 19 ends the current cell. An accumulator MSB of 0 marks the first half-cell, and an MSB of 1 marks the second.
- R8: A cell carrying 1 outputs the latched high code in its first half and black in its second half. A cell carrying 0 outputs the reverse.
- R9: A burst is made of two run-in cells carrying 1, then start-code cells carrying 0 and then 1, then the payload bits. ins_active falls in the cycle after the carry that ends the last payload cell.
- R10: The enables, word, increment, high code, offset and mode select are captured only on a frame_start pulse. Changing them between pulses has no effect on the output, and before the first pulse nothing is inserted.
- R11: After reset, ins_active is low and luma_out equals the black code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at frame start; latches all settings |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | 10 | Absolute line number, valid with line_start |
| hpos | input | 12 | Horizontal sample position within the line |
| std625 | input | 1 | 0 selects 525-line mode, 1 selects 625-line mode |
| en_odd | input | 1 | Odd-field insertion enable |
| en_even | input | 1 | Even-field insertion enable (525-line mode only) |
| wss_word | input | 20 | Data word; bit 0 is sent first |
| rate_inc | input | 20 | Phase accumulator increment per clock |
| hi_code | input | 10 | Luma code for the high level |
| start_ofs | input | 12 | hpos value at which the burst begins |
| luma_out | output | 10 | Luma override value |
| ins_active | output | 1 | High while a burst is being sent |

## Verification
The bench targets the settings that flip with the line standard. It checks that the even-field enable does nothing in 625-line mode, that line 23 stays silent in 525-line mode, and that the upper six word bits reach the output in 525-line mode but vanish in 625-line mode. A wrong design would insert on the wrong line or emit 20 cells where 14 belong. Setting changes made mid-frame are checked to leave the burst untouched, which catches a design with transparent settings that sends a mixed word. Two rate increments and two start offsets are used. An off-by-one in cell length, in the half-cell split or in the start cycle shows up as a shifted or lengthened sample stream, and a late fall of ins_active shows up as an unexpected sample.

// File: rtl/wss_pkg.sv
package wss_pkg;

    localparam int DATA_W    = 20;
    localparam int PAY_BITS  = 14;
    localparam int ACC_W     = 20;
    localparam int LINE_W    = 10;
    localparam int HPOS_W    = 12;
    localparam int LUMA_W    = 10;
    localparam int CNT_W     = $clog2(DATA_W);

    localparam int RUNIN_LEN = 2;
    localparam int START_LEN = 2;
    // sent lowest bit first: 0 then 1
    localparam logic [START_LEN-1:0] START_CODE = 2'b10;

    // line selection table: line, standard, which enable gates it
    localparam int NSLOT = 3;
    localparam int SLOT_LINE    [NSLOT] = '{20, 283, 23};
    localparam int SLOT_STD625  [NSLOT] = '{0, 0, 1};
    localparam int SLOT_USE_EN2 [NSLOT] = '{0, 1, 0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUNIN,
        ST_START,
        ST_DATA
    } wss_st_e;

    typedef struct packed {
        logic              std625;
        logic              en1;
        logic              en2;
        logic [DATA_W-1:0] word;
        logic [ACC_W-1:0]  inc;
        logic [LUMA_W-1:0] hi;
        logic [HPOS_W-1:0] ofs;
    } wss_cfg_t;

endpackage

// File: rtl/wss_shadow.sv
module wss_shadow
    import wss_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  wss_cfg_t cfg_in,
    output wss_cfg_t cfg_q
);

    // settings move only at frame start so one field never mixes two words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/wss_line_sel.sv
module wss_line_sel
    import wss_pkg::*;
(
    input  logic              std625,
    input  logic              en1,
    input  logic              en2,
    input  logic [LINE_W-1:0] line_num,
    output logic              line_hit,
    output logic [CNT_W-1:0]  last_idx
);

    logic [NSLOT-1:0] slot_hit;

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            localparam logic [LINE_W-1:0] LN  = LINE_W'(SLOT_LINE[i]);
            localparam logic              STD = (SLOT_STD625[i] != 0);
            localparam logic              UE2 = (SLOT_USE_EN2[i] != 0);
            assign slot_hit[i] = (line_num == LN) && (std625 == STD)
                               && (UE2 ? en2 : en1);
        end
    endgenerate

    assign line_hit = |slot_hit;
    assign last_idx = std625 ? CNT_W'(PAY_BITS - 1) : CNT_W'(DATA_W - 1);

endmodule

// File: rtl/wss_cell_timer.sv
module wss_cell_timer
    import wss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output logic             cell_end,
    output logic             second_half
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

    assign cell_end    = run & sum[ACC_W];
    assign second_half = acc_q[ACC_W-1];

endmodule

// File: rtl/wss_line_inserter.sv
module wss_line_inserter
    import wss_pkg::*;
#(
    parameter int unsigned BLACK_CODE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic [HPOS_W-1:0] hpos,
    input  logic              std625,
    input  logic              en_odd,
    input  logic              en_even,
    input  logic [DATA_W-1:0] wss_word,
    input  logic [ACC_W-1:0]  rate_inc,
    input  logic [LUMA_W-1:0] hi_code,
    input  logic [HPOS_W-1:0] start_ofs,
    output logic [LUMA_W-1:0] luma_out,
    output logic              ins_active
);

    localparam logic [LUMA_W-1:0] BLACK     = LUMA_W'(BLACK_CODE);
    localparam logic [DATA_W-1:0] START_VEC = DATA_W'(START_CODE);

    wss_cfg_t          cfg_in;
    wss_cfg_t          cfg_q;
    logic              line_hit;
    logic [CNT_W-1:0]  last_idx;
    logic              acc_clr;
    logic              running;
    logic              cell_end;
    logic              half2;
    logic              cur_bit;
    logic              data_last;
    logic [HPOS_W-1:0] ofs_q;
    logic [LUMA_W-1:0] hi_q;

    wss_st_e           st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    assign cfg_in = '{std625: std625, en1: en_odd, en2: en_even,
                      word: wss_word, inc: rate_inc, hi: hi_code,
                      ofs: start_ofs};

    wss_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_start),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    wss_line_sel u_sel (
        .std625   (cfg_q.std625),
        .en1      (cfg_q.en1),
        .en2      (cfg_q.en2),
        .line_num (line_num),
        .line_hit (line_hit),
        .last_idx (last_idx)
    );

    wss_cell_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (acc_clr),
        .run         (running),
        .inc         (cfg_q.inc),
        .cell_end    (cell_end),
        .second_half (half2)
    );

    assign ofs_q     = cfg_q.ofs;
    assign hi_q      = cfg_q.hi;
    assign running   = (st_q == ST_RUNIN) || (st_q == ST_START)
                    || (st_q == ST_DATA);
    assign data_last = (cnt_q == last_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        acc_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                acc_clr = 1'b1;
                if (line_start && line_hit) begin
                    st_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                acc_clr = 1'b1;
                if (line_start) begin
                    st_d = line_hit ? ST_ARMED : ST_IDLE;
                end else if (hpos == cfg_q.ofs) begin
                    st_d  = ST_RUNIN;
                    cnt_d = '0;
                end
            end
            ST_RUNIN: begin
                if (cell_end) begin
                    if (cnt_q == CNT_W'(RUNIN_LEN - 1)) begin
                        st_d  = ST_START;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_START: begin
                if (cell_end) begin
                    if (cnt_q == CNT_W'(START_LEN - 1)) begin
                        st_d  = ST_DATA;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (cell_end) begin
                    if (data_last) begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
        // a new line start ends any burst in progress
        if (running && line_start) begin
            st_d  = line_hit ? ST_ARMED : ST_IDLE;
            cnt_d = '0;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_RUNIN: cur_bit = 1'b1;
            ST_START: cur_bit = START_VEC[cnt_q];
            ST_DATA:  cur_bit = cfg_q.word[cnt_q];
            default:  cur_bit = 1'b0;
        endcase
        ins_active = running;
        luma_out   = (running && (cur_bit ^ half2)) ? cfg_q.hi : BLACK;
    end

endmodule

// File: rtl/wss_checker.sv
module wss_checker
    import wss_pkg::*;
#(
    parameter int unsigned BLACK_CODE = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic [HPOS_W-1:0] hpos,
    input logic [HPOS_W-1:0] ofs,
    input wss_st_e           st,
    input logic              cell_end,
    input logic              data_last,
    input logic              ins_active,
    input logic [LUMA_W-1:0] luma,
    input logic [LUMA_W-1:0] hi
);

    localparam logic [LUMA_W-1:0] BLACK = LUMA_W'(BLACK_CODE);

    logic sending;
    assign sending = (st == ST_RUNIN) || (st == ST_START) || (st == ST_DATA);

    // R5
    a_r5_start_at_offset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_active) |-> ($past(hpos) == $past(ofs)));

    // R6
    a_r6_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_active |-> (luma == BLACK));

    // R8
    a_r8_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ins_active |-> ((luma == hi) || (luma == BLACK)));

    // R7
    a_r7_hold_without_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !cell_end && !line_start) |=> (st == $past(st)));

    // R9
    a_r9_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && cell_end && data_last && !line_start) |=> !ins_active);

endmodule

bind wss_line_inserter wss_checker #(.BLACK_CODE(BLACK_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .hpos       (hpos),
    .ofs        (ofs_q),
    .st         (st_q),
    .cell_end   (cell_end),
    .data_last  (data_last),
    .ins_active (ins_active),
    .luma       (luma_out),
    .hi         (hi_q)
);

// File: tb/sim_wss_line_inserter.sv
module sim_wss_line_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_LEN   = 300;
    localparam int BLACK      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  line_num = '0;
    logic [11:0] hpos = '0;
    logic        std625 = 1'b0;
    logic        en_odd = 1'b0;
    logic        en_even = 1'b0;
    logic [19:0] wss_word = '0;
    logic [19:0] rate_inc = '0;
    logic [9:0]  hi_code = '0;
    logic [11:0] start_ofs = '0;
    logic [9:0]  luma_out;
    logic        ins_active;

    always #(CLK_PERIOD/2) clk = ~clk;

    wss_line_inserter u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .line_num(line_num), .hpos(hpos),
        .std625(std625), .en_odd(en_odd), .en_even(en_even),
        .wss_word(wss_word), .rate_inc(rate_inc), .hi_code(hi_code),
        .start_ofs(start_ofs), .luma_out(luma_out), .ins_active(ins_active)
    );

    logic [9:0]  exp_q[$];
    logic [9:0]  exp_v;
    int          n_chk = 0;
    int          n_fail = 0;
    string       tag = "R11";
    logic        prev_act = 1'b0;
    int          ofs_exp = 0;

    task automatic check(input string t, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    // monitor: compares each active sample against the scoreboard
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (ins_active) begin
            if (!prev_act) check({tag, " R5 start hpos"}, int'(hpos), ofs_exp);
            if (exp_q.size() == 0) begin
                check({tag, " unexpected insert"}, 1, 0);
            end else begin
                exp_v = exp_q.pop_front();
                check({tag, " sample"}, int'(luma_out), int'(exp_v));
            end
        end
        prev_act = ins_active;
    end

    // driver side model of one burst (R7 R8 R9)
    task automatic push_stream(input logic [19:0] d, input int nb,
                               input logic [9:0] hi, input logic [19:0] inc);
        logic [20:0] acc;
        logic        b;
        acc = '0;
        for (int c = 0; c < 4 + nb; c++) begin
            if (c < 2)       b = 1'b1;
            else if (c == 2) b = 1'b0;
            else if (c == 3) b = 1'b1;
            else             b = d[c-4];
            do begin
                exp_q.push_back((b ^ acc[19]) ? hi : 10'(BLACK));
                acc = {1'b0, acc[19:0]} + {1'b0, inc};
            end while (!acc[20]);
            acc[20] = 1'b0;
        end
    endtask

    task automatic run_line(input int ln);
        @(negedge clk);
        line_start = 1'b1;
        line_num   = 10'(ln);
        hpos       = '0;
        for (int h = 1; h < LINE_LEN; h++) begin
            @(negedge clk);
            line_start = 1'b0;
            hpos       = 12'(h);
        end
        @(negedge clk);
        check({tag, " all expected samples seen"}, exp_q.size(), 0);
        exp_q.delete();
        check({tag, " R6 idle active"}, int'(ins_active), 0);
        check({tag, " R6 idle black"}, int'(luma_out), BLACK);
    endtask

    task automatic load_frame(input logic s, input logic e1, input logic e2,
                              input logic [19:0] d, input logic [19:0] inc,
                              input logic [9:0] hi, input logic [11:0] ofs);
        @(negedge clk);
        std625 = s; en_odd = e1; en_even = e2; wss_word = d;
        rate_inc = inc; hi_code = hi; start_ofs = ofs;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset active", int'(ins_active), 0);
        check("R11 reset black", int'(luma_out), BLACK);

        // R10: settings present but never latched
        tag = "R10 before first frame";
        std625 = 1'b0; en_odd = 1'b1; en_even = 1'b1;
        wss_word = 20'hFFFFF; rate_inc = 20'h20000; hi_code = 10'd200;
        run_line(20);

        // frame A: 525, both enables, 8-clock cells
        load_frame(1'b0, 1'b1, 1'b1, 20'hA5C3F, 20'h20000, 10'd200, 12'd20);
        ofs_exp = 20;
        tag = "R1 R3 R8 R9 line 20";
        push_stream(20'hA5C3F, 20, 10'd200, 20'h20000);
        run_line(20);
        tag = "R1 R3 line 283";
        push_stream(20'hA5C3F, 20, 10'd200, 20'h20000);
        run_line(283);
        tag = "R1 line 23 in 525";
        run_line(23);

        // frame B: only even enable, 4-clock cells, other offset
        load_frame(1'b0, 1'b0, 1'b1, 20'h3C0F5, 20'h40000, 10'd300, 12'd37);
        ofs_exp = 37;
        tag = "R1 odd disabled";
        run_line(20);
        tag = "R7 R5 line 283 fast";
        push_stream(20'h3C0F5, 20, 10'd300, 20'h40000);
        run_line(283);

        // R10: change settings mid-frame, burst must not change
        @(negedge clk);
        std625 = 1'b1; en_odd = 1'b1; en_even = 1'b0; wss_word = 20'hFFFFF;
        rate_inc = 20'h20000; hi_code = 10'd500; start_ofs = 12'd20;
        tag = "R10 mid-frame change";
        push_stream(20'h3C0F5, 20, 10'd300, 20'h40000);
        run_line(283);

        // frame C: 625 line 23
        load_frame(1'b1, 1'b1, 1'b0, 20'hFC123, 20'h20000, 10'd150, 12'd20);
        ofs_exp = 20;
        tag = "R4 R2 line 23";
        push_stream(20'hFC123, 14, 10'd150, 20'h20000);
        run_line(23);
        tag = "R2 line 20 in 625";
        run_line(20);
        tag = "R2 line 283 in 625";
        run_line(283);

        // frame D: 625 with only even enable
        load_frame(1'b1, 1'b0, 1'b1, 20'hFC123, 20'h20000, 10'd150, 12'd20);
        tag = "R2 even enable ignored line 23";
        run_line(23);
        tag = "R2 even enable ignored line 283";
        run_line(283);

        // frame E: upper bits differ, same output expected
        load_frame(1'b1, 1'b1, 1'b0, 20'h00123, 20'h20000, 10'd150, 12'd20);
        tag = "R4 upper bits ignored";
        push_stream(20'hFC123, 14, 10'd150, 20'h20000);
        run_line(23);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule